// File: doc/BRIEF.md
# Memory Operand Length Predecoder

This block looks at the bytes that follow the prefixes of a 64-bit mode instruction and works out how long its addressing part is. It takes the REX extension bits, an address-size override flag, a flag that marks the accumulator absolute-address opcodes (A0 to A3), and the ModRM and SIB bytes. From these it decides whether a SIB byte follows and how many displacement or absolute-address bytes come after it. It also returns the base and index register numbers and a flag for the case where no index register is used.

The SIB-presence test and the no-base test look only at the raw 3-bit fields and ignore REX.B. Because of this, an r/m that REX.B extends to register 12 still needs a SIB byte. Index decoding does use REX.X, so register 12 is a valid index while the stack pointer is not. The inputs are sampled on a valid strobe, and every result is registered and appears one cycle later.

Top module: `modrm_len_predec`

## Requirements
- R1: With mod≠11b and raw r/m=100b (bits 2:0 of ModRM), sib_present is 1 whatever REX.B holds. With any other r/m, or with mod=11b (bits 7:6), it is 0.
- R2: With mod=11b, disp_bytes is 0 and sib_present is 0.
- R3: mod=01b gives disp_bytes=1 and mod=10b gives disp_bytes=4.
- R4: mod=00b with raw r/m=101b is RIP-relative: disp_bytes=4, rip_rel=1 and no_base=1, whatever REX.B holds.
- R5: When a SIB is present with mod=00b and raw SIB base (bits 2:0)=101b, disp_bytes=4 and no_base=1, whatever REX.B holds.
- R6: base_reg = {REX.B, r/m} when there is no SIB, and {REX.B, SIB base} when there is one.
- R7: With a SIB present, index_reg = {REX.X, SIB index (bits 5:3)}. no_index=1 only when that 4-bit value is 0100b, so index 100b with REX.X=1 selects register 12.
- R8: With moffs_op=1, disp_bytes is 8, or 4 when addr32 is set. sib_present is 0 and the ModRM byte is not counted.
- R9: total_len = 1 + sib_present + disp_bytes for ModRM forms, and total_len = disp_bytes for moffs forms.
- R10: Outputs update exactly one clock after in_valid is high and hold their value otherwise. out_valid is high for exactly that one cycle. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe that captures the inputs |
| rex_b | input | 1 | REX base/rm extension bit |
| rex_x | input | 1 | REX index extension bit |
| addr32 | input | 1 | Address-size override prefix present |
| moffs_op | input | 1 | Opcode is an accumulator absolute-address form |
| modrm | input | 8 | ModRM byte |
| sib | input | 8 | SIB byte (ignored when none is present) |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| sib_present | output | 1 | A SIB byte follows ModRM |
| disp_bytes | output | 4 | Displacement or absolute-address byte count |
| total_len | output | 4 | Length of the addressing portion in bytes |
| base_reg | output | 4 | Base register number |
| index_reg | output | 4 | Index register number |
| no_base | output | 1 | No base register (RIP-relative or disp32 only) |
| no_index | output | 1 | No index register |
| rip_rel | output | 1 | RIP-relative addressing |

## Verification
Each result shows up on the ports in the cycle after the rising edge that saw in_valid high. The bench drives the inputs with in_valid at a negative edge and lets one rising edge pass. It samples at the next negative edge, so it is checking the registered result from that capture. Cycles with in_valid low are then checked to confirm that the outputs held and that out_valid dropped. Every mod, r/m and SIB-base combination is swept with both REX bits at 0 and at 1, and seeded random bytes plus the moffs cases are added on top.

// File: rtl/predec_pkg.sv
package predec_pkg;
  localparam int unsigned REG_W = 4;
  localparam int unsigned LEN_W = 4;
  localparam logic [1:0] MOD_IND    = 2'b00;
  localparam logic [1:0] MOD_D8     = 2'b01;
  localparam logic [1:0] MOD_D32    = 2'b10;
  localparam logic [1:0] MOD_REG    = 2'b11;
  localparam logic [2:0] RM_ESC_SIB = 3'b100;
  localparam logic [2:0] RM_NOBASE  = 3'b101;

  typedef struct packed {
    logic             sib_present;
    logic [LEN_W-1:0] disp_bytes;
    logic [LEN_W-1:0] total_len;
    logic [REG_W-1:0] base_reg;
    logic [REG_W-1:0] index_reg;
    logic             no_base;
    logic             no_index;
    logic             rip_rel;
  } predec_res_t;
endpackage

// File: rtl/predec_form.sv
module predec_form
  import predec_pkg::*;
(
  input  logic [7:0] modrm,
  input  logic [7:0] sib,
  input  logic       moffs_op,
  input  logic       addr32,
  output logic       sib_present,
  output logic       rip_rel,
  output logic       sib_nobase,
  output logic [LEN_W-1:0] disp_bytes
);
  logic [1:0] mod_f;
  logic [2:0] rm_f;
  logic [2:0] sbase_f;

  always_comb begin
    mod_f   = modrm[7:6];
    rm_f    = modrm[2:0];
    sbase_f = sib[2:0];
    sib_present = 1'b0;
    rip_rel     = 1'b0;
    sib_nobase  = 1'b0;
    disp_bytes  = '0;
    if (moffs_op) begin
      disp_bytes = addr32 ? LEN_W'(4) : LEN_W'(8);
    end else if (mod_f != MOD_REG) begin
      sib_present = (rm_f == RM_ESC_SIB);
      case (mod_f)
        MOD_D8:  disp_bytes = LEN_W'(1);
        MOD_D32: disp_bytes = LEN_W'(4);
        default: begin
          if (rm_f == RM_NOBASE) begin
            rip_rel    = 1'b1;
            disp_bytes = LEN_W'(4);
          end else if (sib_present && sbase_f == RM_NOBASE) begin
            sib_nobase = 1'b1;
            disp_bytes = LEN_W'(4);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/predec_regs.sv
module predec_regs
  import predec_pkg::*;
(
  input  logic [7:0] modrm,
  input  logic [7:0] sib,
  input  logic       rex_b,
  input  logic       rex_x,
  input  logic       sib_present,
  output logic [REG_W-1:0] base_reg,
  output logic [REG_W-1:0] index_reg,
  output logic       no_index
);
  localparam logic [REG_W-1:0] SP_NUM = REG_W'(4);

  always_comb begin
    base_reg  = sib_present ? {rex_b, sib[2:0]} : {rex_b, modrm[2:0]};
    index_reg = '0;
    no_index  = 1'b1;
    if (sib_present) begin
      index_reg = {rex_x, sib[5:3]};
      no_index  = (index_reg == SP_NUM);
    end
  end
endmodule

// File: rtl/modrm_len_predec.sv
module modrm_len_predec
  import predec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       rex_b,
  input  logic       rex_x,
  input  logic       addr32,
  input  logic       moffs_op,
  input  logic [7:0] modrm,
  input  logic [7:0] sib,
  output logic       out_valid,
  output logic       sib_present,
  output logic [3:0] disp_bytes,
  output logic [3:0] total_len,
  output logic [3:0] base_reg,
  output logic [3:0] index_reg,
  output logic       no_base,
  output logic       no_index,
  output logic       rip_rel
);
  logic             f_sib, f_rip, f_sibnb;
  logic [LEN_W-1:0] f_disp;
  logic [REG_W-1:0] f_base, f_index;
  logic             f_noidx;
  predec_res_t      res_d, res_q;
  logic             vld_d, vld_q;

  predec_form u_form (
    .modrm(modrm), .sib(sib), .moffs_op(moffs_op), .addr32(addr32),
    .sib_present(f_sib), .rip_rel(f_rip), .sib_nobase(f_sibnb),
    .disp_bytes(f_disp)
  );

  predec_regs u_regs (
    .modrm(modrm), .sib(sib), .rex_b(rex_b), .rex_x(rex_x),
    .sib_present(f_sib), .base_reg(f_base), .index_reg(f_index),
    .no_index(f_noidx)
  );

  always_comb begin
    res_d = res_q;
    vld_d = in_valid;
    if (in_valid) begin
      res_d.sib_present = f_sib;
      res_d.disp_bytes  = f_disp;
      res_d.total_len   = moffs_op ? f_disp
                                   : LEN_W'(1) + LEN_W'(f_sib) + f_disp;
      res_d.base_reg    = f_base;
      res_d.index_reg   = f_index;
      res_d.no_base     = f_rip | f_sibnb;
      res_d.no_index    = f_noidx;
      res_d.rip_rel     = f_rip;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (in_valid) res_q <= res_d;
    end
  end

  assign out_valid   = vld_q;
  assign sib_present = res_q.sib_present;
  assign disp_bytes  = res_q.disp_bytes;
  assign total_len   = res_q.total_len;
  assign base_reg    = res_q.base_reg;
  assign index_reg   = res_q.index_reg;
  assign no_base     = res_q.no_base;
  assign no_index    = res_q.no_index;
  assign rip_rel     = res_q.rip_rel;

  p_sib_from_raw_rm_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !moffs_op && modrm[7:6] != 2'b11 && modrm[2:0] == 3'b100)
    |=> sib_present);
  p_reg_form_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !moffs_op && modrm[7:6] == 2'b11)
    |=> (disp_bytes == 4'd0 && !sib_present));
  p_rip_rel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !moffs_op && modrm[7:6] == 2'b00 && modrm[2:0] == 3'b101)
    |=> (rip_rel && no_base && disp_bytes == 4'd4));
  p_r12_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !moffs_op && modrm[7:6] != 2'b11 && modrm[2:0] == 3'b100
     && rex_x && sib[5:3] == 3'b100) |=> !no_index);
  p_moffs_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && moffs_op) |=> (!sib_present && disp_bytes == (addr32 ? 4'd4 : 4'd8)));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(total_len) && $stable(base_reg) && !out_valid));
endmodule

// File: tb/sim_modrm_len_predec.sv
module sim_modrm_len_predec;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, rex_b = 1'b0, rex_x = 1'b0, addr32 = 1'b0, moffs_op = 1'b0;
  logic [7:0] modrm = '0, sib = '0;
  logic out_valid, sib_present, no_base, no_index, rip_rel;
  logic [3:0] disp_bytes, total_len, base_reg, index_reg;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modrm_len_predec u0 (.*);

  function automatic logic [31:0] ref_model(input logic b, input logic x, input logic a32,
      input logic mo, input logic [7:0] m, input logic [7:0] s);
    logic sp; logic [3:0] d, t, br, ir; logic nb, ni, rr;
    sp = 0; d = 0; nb = 0; ni = 1; rr = 0; ir = 0;
    if (mo) d = a32 ? 4'd4 : 4'd8;
    else if (m[7:6] != 2'b11) begin
      sp = (m[2:0] == 3'd4);
      if (m[7:6] == 2'b01) d = 1;
      else if (m[7:6] == 2'b10) d = 4;
      else if (m[2:0] == 3'd5) begin d = 4; rr = 1; nb = 1; end
      else if (sp && s[2:0] == 3'd5) begin d = 4; nb = 1; end
    end
    br = sp ? {b, s[2:0]} : {b, m[2:0]};
    if (sp) begin ir = {x, s[5:3]}; ni = (ir == 4'd4); end
    t = mo ? d : 4'd1 + {3'd0, sp} + d;
    return {13'd0, sp, d, t, br, ir, nb, ni, rr};
  endfunction

  function automatic logic [31:0] got();
    return {13'd0, sib_present, disp_bytes, total_len, base_reg, index_reg,
            no_base, no_index, rip_rel};
  endfunction

  function automatic string tag_of(input logic mo, input logic [7:0] m, input logic [7:0] s,
      input logic x);
    if (mo) return "R8/R9";
    if (m[7:6] == 2'b11) return "R2/R9";
    if (m[7:6] == 2'b00 && m[2:0] == 3'd5) return "R4/R9";
    if (m[2:0] == 3'd4 && m[7:6] == 2'b00 && s[2:0] == 3'd5) return "R5/R9";
    if (m[2:0] == 3'd4 && s[5:3] == 3'd4) return x ? "R7_r12" : "R7_none";
    if (m[2:0] == 3'd4) return "R1/R6";
    return "R3/R6";
  endfunction

  task automatic apply(input logic b, input logic x, input logic a32, input logic mo,
      input logic [7:0] m, input logic [7:0] s);
    logic [31:0] e;
    @(negedge clk);
    rex_b = b; rex_x = x; addr32 = a32; moffs_op = mo; modrm = m; sib = s; in_valid = 1;
    e = ref_model(b, x, a32, mo, m, s);
    @(negedge clk);
    in_valid = 0;
    n_run++;
    if (got() !== e || out_valid !== 1'b1) begin
      n_fail++;
      $display("FAIL %s: got %h vld %b expected %h vld 1", tag_of(mo, m, s, x), got(), out_valid, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold;
    #(CLK_PERIOD * 2 + 3);
    n_run++;
    if (got() !== 32'd0 || out_valid !== 1'b0) begin
      n_fail++; $display("FAIL R10 reset: got %h expected 0", got());
    end
    rst_n = 1;
    // exhaustive mod/rm/sib-base with both REX bits; SIB index cycled
    for (int mo = 0; mo < 4; mo++)
      for (int rm = 0; rm < 8; rm++)
        for (int sb = 0; sb < 8; sb++)
          for (int bx = 0; bx < 4; bx++)
            apply(bx[0], bx[1], 1'b0, 1'b0, {mo[1:0], 3'(rm + sb), rm[2:0]},
                  {2'(bx), 3'(sb + bx), sb[2:0]});
    // R7: explicit index 100b with REX.X 0 and 1
    apply(0, 0, 0, 0, 8'h04, 8'h20);
    apply(0, 1, 0, 0, 8'h04, 8'h20);
    // R1: REX 0x41 with r/m 100b still needs SIB
    apply(1, 0, 0, 0, 8'h44, 8'h00);
    // R8: moffs forms
    apply(0, 0, 0, 1, 8'hFF, 8'hFF);
    apply(1, 1, 1, 1, 8'h04, 8'h05);
    void'($urandom(32'd1234));
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r = $urandom;
      apply(r[0], r[1], r[2], r[3] & r[4], r[15:8], r[23:16]);
    end
    // R10: outputs hold while in_valid low, even with inputs changing
    @(negedge clk);
    hold = got();
    modrm = 8'h55; sib = 8'hAA; rex_b = ~rex_b; moffs_op = 1;
    @(negedge clk); @(negedge clk);
    n_run++;
    if (got() !== hold || out_valid !== 1'b0) begin
      n_fail++; $display("FAIL R10 hold: got %h vld %b expected %h vld 0", got(), out_valid, hold);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule